// File: doc/BRIEF.md
# Periodic Round-Robin Stream Arbiter

This block decides which of two memory-to-memory transfer streams owns the data path in each clock cycle. Each stream raises a request while it has work queued. Each stream also raises a ready flag in any cycle where it can move one data word. The arbiter produces a one-hot grant and a per-stream data strobe. The strobe marks the cycles in which the granted stream actually transfers.

Once a stream moves a word, the selection locks onto that stream. The lock lasts until the stream has completed a programmable number P of data cycles, or until it stalls. When a period ends, priority passes to the other stream. If the other stream is waiting, it takes over in the very next cycle, so alternation costs nothing. If the other stream is not waiting, that next cycle goes idle before the same stream can start a new period. A lone stream therefore reaches P/(P+1) of full throughput. This lets a system trade alternation frequency against efficiency when it picks P.

Top module: `rr_stream_arb`

## Requirements
- R1: A stream that starts a period while both streams are requesting and always ready keeps the grant for exactly P consecutive data cycles before the other stream is granted.
- R2: With only stream 0 requesting and always ready, the grant pattern from reset repeats P granted data cycles followed by one cycle with no grant, giving 12 transfers in 16 cycles for P=3.
- R3: With both streams requesting and always ready, a transfer happens in every cycle, and ownership alternates every P cycles without idle cycles.
- R4: When the granted stream is not ready, its strobe stays low in that cycle and the lock output reads 0 in the next cycle. Priority is unchanged, so the same stream is selected again if it still requests.
- R5: While the lock output is 1, the grant stays on the locked stream even if the other stream starts requesting.
- R6: A period setting of 0 behaves as P=1, so two busy streams swap the grant every cycle.
- R7: After reset the lock output is 0. With both streams requesting, the first grant goes to stream 0 (grant = 2'b01).
- R8: After a period ends, the stream that did not hold the last grant has priority for the next grant.
- R9: The grant is one-hot or zero (bit i selects stream i). The strobe equals grant AND request AND ready, so at most one strobe bit is high.
- R10: A new period setting written while a stream is locked takes effect only at the start of the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| period_cfg | input | PERIOD_W (4) | Round-robin period P; 0 is treated as 1 |
| req_i | input | 2 | Per-stream request (bit i = stream i) |
| rdy_i | input | 2 | Per-stream ready for a data cycle |
| grant_o | output | 2 | One-hot selected stream, or zero |
| xfer_o | output | 2 | Data-cycle strobe per stream |
| locked_o | output | 1 | Selection currently locked to a stream |

## Verification
The embedded properties take for granted that request and ready inputs are stable by the clock edge. They need no ordering between request and ready; ready without request is simply ignored. The bench drives requests, ready flags and the period setting at the falling edge, with random bias towards long runs, and changes the period setting only now and then. This means both mid-period changes and changes at a boundary occur. Directed sequences cover a lone stream, two busy streams, a zero period, a stall during a lock and a mid-lock period change.

// File: rtl/rr_arb_pkg.sv
// Package: shared constants and the selection record used by the
// arbiter submodules. Assumes exactly two streams.
package rr_arb_pkg;
    localparam int NUM_STREAMS = 2;
    localparam int IDX_W       = 1;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
    } sel_t;
endpackage

// File: rtl/rr_period_ctr.sv
// Period counter: counts data cycles inside the current locked run and
// flags the last one. The period setting is sampled when a run begins and
// held for the rest of the run. Assumes locked is low whenever the run
// has not started.
module rr_period_ctr #(
    parameter int PERIOD_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PERIOD_W-1:0] period_cfg,
    input  logic                locked,
    input  logic                data_cycle,
    output logic                expire
);
    localparam logic [PERIOD_W-1:0] ONE = PERIOD_W'(1);

    logic [PERIOD_W-1:0] cnt_q;
    logic [PERIOD_W-1:0] plat_q;
    logic [PERIOD_W-1:0] eff_cfg;
    logic [PERIOD_W-1:0] p_use;
    logic [PERIOD_W-1:0] cnt_inc;

    // Map a zero setting to one and choose the live or held period.
    always_comb begin
        eff_cfg = (period_cfg == '0) ? ONE : period_cfg;
        p_use   = locked ? plat_q : eff_cfg;
        cnt_inc = cnt_q + ONE;
        expire  = data_cycle && (cnt_inc == p_use);
    end

    // Advance the run count, and capture the period when a run starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            plat_q <= ONE;
        end else if (data_cycle) begin
            if (!locked) plat_q <= eff_cfg;
            cnt_q <= expire ? '0 : cnt_inc;
        end else begin
            cnt_q <= '0;
        end
    end

    AST_COUNT_BELOW_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> (cnt_q != '0 && cnt_q < plat_q)); // R1

    AST_PERIOD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && $past(locked)) |-> $stable(plat_q)); // R10
endmodule

// File: rtl/rr_lock_ctl.sv
// Lock controller: holds the lock, the owning stream, the priority
// pointer and the one-cycle turnaround flag raised after a period ends.
// Assumes sel and data_cycle describe the same cycle.
module rr_lock_ctl
    import rr_arb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  sel_t             sel,
    input  logic             data_cycle,
    input  logic             expire,
    output logic             locked,
    output logic [IDX_W-1:0] owner,
    output logic [IDX_W-1:0] prio,
    output logic             turn
);
    // Update lock, owner, priority and turnaround from this cycle's outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked <= 1'b0;
            owner  <= '0;
            prio   <= '0;
            turn   <= 1'b0;
        end else begin
            locked <= data_cycle && !expire;
            if (data_cycle) owner <= sel.idx;
            if (expire)     prio  <= ~sel.idx;
            turn   <= expire;
        end
    end

    AST_UNLOCK_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (sel.valid && !data_cycle) |=> !locked); // R4

    AST_PRIO_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (turn && prio != $past(sel.idx))); // R8
endmodule

// File: rtl/rr_grant_sel.sv
// Grant selector: picks the stream to select this cycle. A locked owner
// always wins; in the turnaround cycle only the priority stream may be
// chosen; otherwise the priority stream first, then the other one.
// Purely combinational.
module rr_grant_sel
    import rr_arb_pkg::*;
(
    input  logic [NUM_STREAMS-1:0] req,
    input  logic                   locked,
    input  logic [IDX_W-1:0]       owner,
    input  logic [IDX_W-1:0]       prio,
    input  logic                   turn,
    output sel_t                   sel
);
    logic [IDX_W-1:0] other;

    // Resolve the selection from lock state and requests.
    always_comb begin
        other = ~prio;
        sel   = '0;
        if (locked) begin
            sel.valid = 1'b1;
            sel.idx   = owner;
        end else if (req[prio]) begin
            sel.valid = 1'b1;
            sel.idx   = prio;
        end else if (!turn && req[other]) begin
            sel.valid = 1'b1;
            sel.idx   = other;
        end
    end
endmodule

// File: rtl/rr_stream_arb.sv
// Top: periodic round-robin arbiter for two transfer streams. Decodes the
// selection to a one-hot grant and forms the per-stream data strobes.
// Assumes req_i and rdy_i are synchronous to clk.
module rr_stream_arb
    import rr_arb_pkg::*;
#(
    parameter int PERIOD_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [PERIOD_W-1:0]    period_cfg,
    input  logic [NUM_STREAMS-1:0] req_i,
    input  logic [NUM_STREAMS-1:0] rdy_i,
    output logic [NUM_STREAMS-1:0] grant_o,
    output logic [NUM_STREAMS-1:0] xfer_o,
    output logic                   locked_o
);
    sel_t             sel;
    logic             locked;
    logic [IDX_W-1:0] owner;
    logic [IDX_W-1:0] prio;
    logic             turn;
    logic             data_cycle;
    logic             expire;

    rr_grant_sel u_sel (
        .req    (req_i),
        .locked (locked),
        .owner  (owner),
        .prio   (prio),
        .turn   (turn),
        .sel    (sel)
    );

    // One-hot grant decode and strobe per stream.
    for (genvar i = 0; i < NUM_STREAMS; i++) begin : g_stream
        assign grant_o[i] = sel.valid && (sel.idx == IDX_W'(i));
        assign xfer_o[i]  = grant_o[i] && req_i[i] && rdy_i[i];
    end

    assign data_cycle = |xfer_o;
    assign locked_o   = locked;

    rr_period_ctr #(.PERIOD_W(PERIOD_W)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .period_cfg (period_cfg),
        .locked     (locked),
        .data_cycle (data_cycle),
        .expire     (expire)
    );

    rr_lock_ctl u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (sel),
        .data_cycle (data_cycle),
        .expire     (expire),
        .locked     (locked),
        .owner      (owner),
        .prio       (prio),
        .turn       (turn)
    );

    AST_GRANT_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o)); // R9

    AST_STROBE_IN_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(xfer_o) && ((xfer_o & ~grant_o) == '0)); // R9

    AST_LOCK_KEEPS_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_o != '0) |=> (!locked_o || grant_o == $past(grant_o))); // R5

    AST_NO_REPEAT_AFTER_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> ((grant_o & $past(grant_o)) == '0)); // R2
endmodule

// File: tb/rr_stream_arb_test.sv
module rr_stream_arb_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] period_cfg = 4'd0;
    logic [1:0] req_i = 2'b00;
    logic [1:0] rdy_i = 2'b00;
    logic [1:0] grant_o, xfer_o;
    logic       locked_o;

    int n_chk = 0;
    int n_fail = 0;

    // model state
    logic       m_lock, m_own, m_prio, m_turn;
    logic [3:0] m_cnt, m_plat;
    logic [1:0] obs_g, obs_x;
    logic       obs_l;

    always #10 clk = ~clk;   // 50 MHz

    rr_stream_arb uut (
        .clk(clk), .rst_n(rst_n), .period_cfg(period_cfg),
        .req_i(req_i), .rdy_i(rdy_i),
        .grant_o(grant_o), .xfer_o(xfer_o), .locked_o(locked_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] eff_p(input logic [3:0] c);
        return (c == 4'd0) ? 4'd1 : c;
    endfunction

    task automatic model_reset();
        m_lock = 0; m_own = 0; m_prio = 0; m_turn = 0; m_cnt = 0; m_plat = 1;
    endtask

    // One cycle: drive, compare against the model, step the model.
    task automatic tick(input logic [1:0] rq, input logic [1:0] rd, input logic [3:0] pc);
        logic v; logic s; logic [1:0] eg, ex; logic [3:0] pu, nc;
        @(negedge clk);
        req_i = rq; rdy_i = rd; period_cfg = pc;
        #2;
        obs_g = grant_o; obs_x = xfer_o; obs_l = locked_o;
        v = 0; s = 0;
        if (m_lock) begin v = 1; s = m_own; end
        else if (rq[m_prio]) begin v = 1; s = m_prio; end
        else if (!m_turn && rq[~m_prio]) begin v = 1; s = ~m_prio; end
        eg = v ? (2'b01 << s) : 2'b00;
        ex = eg & rq & rd;
        if (rst_n)
            chk(obs_g == eg && obs_x == ex && obs_l == m_lock, "R9 model",
                {obs_l, obs_g, obs_x}, {m_lock, eg, ex});
        @(posedge clk);
        if (!rst_n) model_reset();
        else if (ex != 0) begin
            pu = m_lock ? m_plat : eff_p(pc);
            if (!m_lock) m_plat = eff_p(pc);
            nc = m_cnt + 4'd1;
            if (nc == pu) begin
                m_lock = 0; m_cnt = 0; m_prio = ~s; m_turn = 1;
            end else begin
                m_lock = 1; m_own = s; m_cnt = nc; m_turn = 0;
            end
        end else begin
            m_lock = 0; m_cnt = 0; m_turn = 0;
        end
    endtask

    task automatic do_reset();
        rst_n = 0;
        tick(2'b00, 2'b00, 4'd1);
        tick(2'b00, 2'b00, 4'd1);
        rst_n = 1;
    endtask

    initial begin
        #(20 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int cnt;
        void'($urandom(32'h5eed_1234));
        model_reset();

        // R7: reset state
        do_reset();
        tick(2'b11, 2'b00, 4'd3);
        chk(obs_l == 0, "R7 lock", obs_l, 0);
        chk(obs_g == 2'b01, "R7 grant", obs_g, 1);

        // R2/R1: lone stream, P=3
        do_reset();
        cnt = 0;
        for (int i = 0; i < 16; i++) begin
            tick(2'b01, 2'b11, 4'd3);
            if (obs_x != 0) cnt++;
            if (i < 3) chk(obs_g == 2'b01, "R1 lone run", obs_g, 1);
            if (i == 3) chk(obs_g == 2'b00, "R2 idle", obs_g, 0);
        end
        chk(cnt == 12, "R2 throughput", cnt, 12);

        // R3/R8: both streams, P=2
        do_reset();
        cnt = 0;
        for (int i = 0; i < 8; i++) begin
            tick(2'b11, 2'b11, 4'd2);
            if (obs_x != 0) cnt++;
            chk(obs_g == (((i / 2) % 2) ? 2'b10 : 2'b01), (i == 2) ? "R8 switch" : "R3 alternate",
                obs_g, ((i / 2) % 2) ? 2 : 1);
        end
        chk(cnt == 8, "R3 no idle", cnt, 8);

        // R6: zero period
        do_reset();
        for (int i = 0; i < 6; i++) begin
            tick(2'b11, 2'b11, 4'd0);
            chk(obs_g == ((i % 2) ? 2'b10 : 2'b01), "R6 zero period", obs_g, (i % 2) ? 2 : 1);
        end

        // R4: stall while locked
        do_reset();
        tick(2'b11, 2'b11, 4'd4);
        tick(2'b11, 2'b10, 4'd4);
        chk(obs_l == 1 && obs_g == 2'b01 && obs_x == 2'b00, "R4 stall", {obs_l, obs_g, obs_x}, 3'b101 << 2);
        tick(2'b11, 2'b11, 4'd4);
        chk(obs_l == 0, "R4 unlock", obs_l, 0);
        chk(obs_g == 2'b01 && obs_x == 2'b01, "R4 reselect", {obs_g, obs_x}, 5);

        // R5: lock holds against a new request
        do_reset();
        tick(2'b01, 2'b11, 4'd4);
        for (int i = 0; i < 3; i++) begin
            tick(2'b11, 2'b11, 4'd4);
            chk(obs_g == 2'b01 && obs_l == 1, "R5 hold", {obs_l, obs_g}, 5);
        end
        tick(2'b11, 2'b11, 4'd4);
        chk(obs_g == 2'b10, "R5 rotate", obs_g, 2);

        // R10: period change mid-run
        do_reset();
        tick(2'b11, 2'b11, 4'd4);
        for (int i = 0; i < 3; i++) begin
            tick(2'b11, 2'b11, 4'd2);
            chk(obs_g == 2'b01, "R10 old period", obs_g, 1);
        end
        for (int i = 0; i < 2; i++) begin
            tick(2'b11, 2'b11, 4'd2);
            chk(obs_g == 2'b10, "R10 new period", obs_g, 2);
        end
        tick(2'b11, 2'b11, 4'd2);
        chk(obs_g == 2'b01, "R10 boundary", obs_g, 1);

        // Random traffic checked against the model (R9)
        do_reset();
        begin
            logic [1:0] rq, rd; logic [3:0] pc;
            rq = 2'b11; rd = 2'b11; pc = 4'd3;
            for (int i = 0; i < 4000; i++) begin
                if ($urandom_range(0, 7) == 0) rq = 2'($urandom);
                rd = ($urandom_range(0, 3) == 0) ? 2'($urandom) : 2'b11;
                if ($urandom_range(0, 40) == 0) pc = 4'($urandom);
                if ($urandom_range(0, 999) == 0) begin
                    do_reset();
                end
                tick(rq, rd, pc);
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule